// File: doc/BRIEF.md
# Multiply-Accumulate Coprocessor with Private Register File

This block is a multicycle coprocessor that sits next to a CPU datapath. Each operation multiplies two 32-bit operands and adds the low half of the product into a 32-bit accumulator. Each operand is picked on its own, either from the CPU operand port or from one of 32 private registers inside the block. The destination is picked the same way: the updated sum goes either back to the CPU on the result port or into a private register.

When the sum goes back to the CPU, the accumulator is cleared in the same step, so the next series of products starts from zero. When the sum goes into a private register, the accumulator keeps the sum and the series continues. Software can therefore keep partial sums and coefficients local to the block and pass only the final value back to the CPU.

An operation is launched with a one-cycle start pulse. `done` rises exactly two cycles later and lasts one cycle. Every register inside the block only advances while the clock enable is high. The synchronous reset clears the accumulator and all private registers.

Top module: `mac_regfile_unit`

## Requirements
- R1: After synchronous reset, `done` is 0, `result` is 0, the accumulator is 0 and all 32 private registers read as 0.
- R2: When `a_from_cpu` is 1 the first factor is `opnd_a`. When it is 0 the first factor is private register `idx_a`, and `opnd_a` has no effect.
- R3: When `b_from_cpu` is 1 the second factor is `opnd_b`. When it is 0 the second factor is private register `idx_b`, and `opnd_b` has no effect.
- R4: Each operation adds the low 32 bits of the 64-bit unsigned product into the 32-bit accumulator, once, with wraparound modulo 2^32.
- R5: When `to_cpu` is 1, `result` carries the updated sum while `done` is high, and the accumulator is 0 afterwards.
- R6: When `to_cpu` is 0, the updated sum is written into private register `idx_c`. The accumulator keeps that sum, and `result` also shows it while `done` is high.
- R7: With the clock enable held high, `done` is 0 in the cycle after `start` and 1 in the second cycle after `start`, for exactly one cycle.
- R8: While `clk_en` is 0, no internal state, `done` or `result` changes. An operation in flight finishes one enabled edge per remaining step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock qualifier for every register |
| start | input | 1 | One-cycle pulse that launches an operation |
| a_from_cpu | input | 1 | 1: first factor from `opnd_a`; 0: from private register |
| b_from_cpu | input | 1 | 1: second factor from `opnd_b`; 0: from private register |
| to_cpu | input | 1 | 1: return sum on `result` and clear; 0: write private register |
| idx_a | input | 5 | Private register number for the first factor |
| idx_b | input | 5 | Private register number for the second factor |
| idx_c | input | 5 | Private register number for the destination |
| opnd_a | input | 32 | First CPU operand |
| opnd_b | input | 32 | Second CPU operand |
| result | output | 32 | Updated sum, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
Operations run through all four source-selection combinations. When an operand comes from a private register, the CPU port carries a distinct junk value, so picking the wrong source gives a visibly wrong sum. Products whose low half is zero (2^32, 2^31·2) and all-ones factors separate correct 32-bit truncation from wider arithmetic or dropped carries. The tests alternate chains that stay local with chains that return to the CPU, which shows whether the clear happens only on return. Writing to registers 0 and 31 and then reading them back covers both ends of the register-number range. A clock-enable stall in mid-operation and a reset after registers were written complete the set.

// File: rtl/mac_regfile_unit.sv
module mac_regfile_unit #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_en,
  input  logic          start,
  input  logic          a_from_cpu,
  input  logic          b_from_cpu,
  input  logic          to_cpu,
  input  logic [IW-1:0] idx_a,
  input  logic [IW-1:0] idx_b,
  input  logic [IW-1:0] idx_c,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] result,
  output logic          done
);

  logic [DW-1:0]   rf [NREG];
  logic            busy;
  logic            ret_q;
  logic [IW-1:0]   dst_q;
  logic [DW-1:0]   fa, fb, acc, res_q;
  logic            done_q;
  logic [2*DW-1:0] prod;
  logic [DW-1:0]   sum;

  assign prod   = fa * fb;
  assign sum    = acc + prod[DW-1:0];
  assign result = res_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ret_q  <= 1'b0;
      dst_q  <= '0;
      fa     <= '0;
      fb     <= '0;
      acc    <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (clk_en) begin
      busy   <= start;
      done_q <= busy;
      if (start) begin
        fa    <= a_from_cpu ? opnd_a : rf[idx_a];
        fb    <= b_from_cpu ? opnd_b : rf[idx_b];
        ret_q <= to_cpu;
        dst_q <= idx_c;
      end
      if (busy) begin
        res_q <= sum;
        if (ret_q) acc <= '0;
        else begin
          acc       <= sum;
          rf[dst_q] <= sum;
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done && clk_en) |=> !done);

  // R7
  start_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && clk_en) |=> (busy && !done));

  // R7
  busy_to_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && clk_en) |=> done);

  // R5
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && clk_en && ret_q) |=> (acc == '0));

  // R6
  local_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && clk_en && !ret_q) |=> (rf[$past(dst_q)] == acc && result == acc));

  // R2
  src_a_chk: assert property (@(posedge clk) disable iff (rst)
    (start && clk_en && !a_from_cpu && !busy) |=> (fa == $past(rf[idx_a])));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(acc) && $stable(result) && $stable(done) && $stable(busy)));

endmodule

// File: tb/test_mac_regfile_unit.sv
module test_mac_regfile_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam int VW = 82;

  // {a_from_cpu, b_from_cpu, to_cpu, idx_a, idx_b, idx_c, opnd_a, opnd_b}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,5'd0,5'd0,5'd3,32'd6,32'd7},
    {1'b1,1'b1,1'b0,5'd0,5'd0,5'd4,32'h0001_0000,32'h0001_0000},
    {1'b0,1'b1,1'b0,5'd3,5'd0,5'd5,32'hDEAD_BEEF,32'd2},
    {1'b1,1'b0,1'b1,5'd0,5'd5,5'd0,32'd3,32'hCAFE_F00D},
    {1'b0,1'b0,1'b0,5'd5,5'd3,5'd6,32'h1234_5678,32'h8765_4321},
    {1'b1,1'b1,1'b1,5'd0,5'd0,5'd0,32'hFFFF_FFFF,32'hFFFF_FFFF},
    {1'b1,1'b1,1'b0,5'd0,5'd0,5'd31,32'h8000_0000,32'd2},
    {1'b0,1'b0,1'b1,5'd6,5'd6,5'd0,32'h5555_5555,32'hAAAA_AAAA},
    {1'b1,1'b1,1'b0,5'd0,5'd0,5'd0,32'd5,32'hFFFF_FFFF},
    {1'b0,1'b1,1'b1,5'd0,5'd0,5'd0,32'h0F0F_0F0F,32'd2}
  };

  logic clk = 1'b0, rst = 1'b1, clk_en = 1'b1, start = 1'b0;
  logic a_from_cpu = 1'b1, b_from_cpu = 1'b1, to_cpu = 1'b1;
  logic [4:0] idx_a = '0, idx_b = '0, idx_c = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [31:0] result;
  logic done;

  int compared = 0, mismatched = 0, cycles = 0;
  logic [31:0] mrf [32];
  logic [31:0] macc;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_regfile_unit i_mac_regfile_unit (
    .clk(clk), .rst(rst), .clk_en(clk_en), .start(start),
    .a_from_cpu(a_from_cpu), .b_from_cpu(b_from_cpu), .to_cpu(to_cpu),
    .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .done(done)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      compared++; mismatched++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      finish_run();
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    macc = '0;
    for (int i = 0; i < 32; i++) mrf[i] = '0;
  endtask

  task automatic run_op(input logic sa, input logic sb, input logic dc,
                        input logic [4:0] ia, input logic [4:0] ib, input logic [4:0] ic,
                        input logic [31:0] da, input logic [31:0] db, input string tag);
    logic [31:0] ea, eb, nacc;
    logic [63:0] p;
    ea = sa ? da : mrf[ia];
    eb = sb ? db : mrf[ib];
    p = 64'(ea) * 64'(eb);
    nacc = macc + p[31:0];
    if (dc) macc = '0;
    else begin macc = nacc; mrf[ic] = nacc; end
    @(negedge clk);
    a_from_cpu = sa; b_from_cpu = sb; to_cpu = dc;
    idx_a = ia; idx_b = ib; idx_c = ic; opnd_a = da; opnd_b = db;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R7 done low one cycle after start"}, {31'd0, done}, 32'd0);
    @(negedge clk);
    check({tag, " R7 done high two cycles after start"}, {31'd0, done}, 32'd1);
    check({tag, " R4 R5 R6 result"}, result, nacc);
    @(negedge clk);
    check({tag, " R7 done single cycle"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    model_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 done after reset", {31'd0, done}, 32'd0);
    check("R1 result after reset", result, 32'd0);
    run_op(1'b0, 1'b1, 1'b1, 5'd7, 5'd0, 5'd0, 32'h1111_1111, 32'd1, "R1 private reg 7 zero");

    // table: R2 R3 select, R4 wrap, R5 return-and-clear, R6 local write (regs 0 and 31)
    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      run_op(v[81], v[80], v[79], v[78:74], v[73:69], v[68:64], v[63:32], v[31:0],
             $sformatf("vec%0d", k));
    end

    // R6 readback of register 31 (written as 0 by wrap) and register 4
    run_op(1'b0, 1'b1, 1'b1, 5'd31, 5'd0, 5'd0, 32'h7777_7777, 32'd1, "R6 readback reg31");
    run_op(1'b0, 1'b0, 1'b1, 5'd4, 5'd3, 5'd0, 32'd0, 32'd0, "R3 R6 readback reg4*reg3");

    // R8 stall in mid-operation
    @(negedge clk);
    a_from_cpu = 1'b1; b_from_cpu = 1'b1; to_cpu = 1'b1;
    opnd_a = 32'd9; opnd_b = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0; clk_en = 1'b0;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check("R8 done held low while disabled", {31'd0, done}, 32'd0);
    end
    clk_en = 1'b1;
    @(negedge clk);
    check("R8 done after stall", {31'd0, done}, 32'd1);
    check("R8 result after stall", result, 32'd81);
    clk_en = 1'b0;
    @(negedge clk);
    check("R8 done frozen while disabled", {31'd0, done}, 32'd1);
    clk_en = 1'b1;
    @(negedge clk);
    check("R8 done falls once enabled", {31'd0, done}, 32'd0);
    macc = '0;

    // R1 reset after registers were written
    run_op(1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 5'd9, 32'd4, 32'd5, "R6 write reg9");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1 result cleared by reset", result, 32'd0);
    run_op(1'b0, 1'b1, 1'b1, 5'd9, 5'd0, 5'd0, 32'hAAAA_0000, 32'd1, "R1 reg9 and acc cleared");

    finish_run();
  end
endmodule